// File: doc/BRIEF.md
# First-Order Sigma-Delta DAC

This block turns a signed 16-bit setpoint into a one-bit pulse stream whose density of ones follows the setpoint. An external RC low-pass filter turns that stream into an analog level. A zero setpoint gives a stream that is high half of the time. The most negative setpoint gives a quarter, and the most positive gives just under three quarters. The modulator is a single accumulator. Each bit tick it adds a code derived from the setpoint, and the carry out of that addition becomes the output bit.

A small register port controls the block. One address holds the setpoint and another holds the run flag, and both can be read back. The bit tick comes from dividing the system clock by a parameter, so the bit rate stays fixed for a given clock. When the run flag is clear, the pin output is released, the bit is forced low and the accumulator is emptied. Each run therefore starts from a known state.

Top module: `sigma_delta_dac`

## Requirements
- R1: After reset the run flag is 0, the setpoint reads 0, and both `dacOut` and `dacDrive` are low.
- R2: The modulator code is C = ((value + 32768) >> 1) + 16384. Starting from an empty accumulator, exactly floor(K*C/65536) of the first K bits are 1, so the density is 1/2 + value/2^17.
- R3: While running, one new bit is produced every TICK_DIV clock cycles. The first bit appears TICK_DIV cycles after the run flag is set, and `dacOut` holds its value between ticks.
- R4: Clearing the run flag forces `dacOut` low and empties the accumulator, so a later run repeats the bit sequence of a fresh start.
- R5: Reads are combinational on `rdAddr`. Address 0 reads the setpoint. Address 1 reads the run flag in bit 0, with all other bits 0. A write to either address lands at the clock edge where `wrEn` is high.
- R6: A setpoint written while running is used from the next tick on, without emptying the accumulator.
- R7: `dacDrive` is high exactly while the run flag is set.
- R8: Addresses 2 and 3 hold nothing: a write there changes neither register, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 16 | Read data |
| dacOut | output | 1 | Pulse-density bit |
| dacDrive | output | 1 | Output enable for the pin |

## Verification
The bench counts the ones over a 1024-tick window for four setpoints: zero, the most negative value, the most positive value and a small positive value. The zero and extreme cases tie the ends and the centre of the transfer line. The small value shows whether the halving and the offset are rounded correctly. Short bit sequences then tell a setpoint change that keeps the accumulator apart from one that restarts it, and show whether a stop followed by a restart really empties the accumulator.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_VALUE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd1;

  typedef struct packed {
    logic run;
    logic tick;
  } sddStrobes_t;
endpackage

// File: rtl/sdd_ctrl.sv
module sdd_ctrl
  import sdd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] setpoint,
  output sddStrobes_t       strb
);
  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

  logic             runFlag;
  logic [CNT_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setpoint <= '0;
      runFlag  <= 1'b0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_VALUE) setpoint <= wrData;
      if (wrAddr == ADDR_CTRL)  runFlag  <= wrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  divCnt <= '0;
    else if (!runFlag)          divCnt <= '0;
    else if (divCnt == CNT_LAST) divCnt <= '0;
    else                        divCnt <= divCnt + 1'b1;
  end

  always_comb begin
    strb.run  = runFlag;
    strb.tick = runFlag && (divCnt == CNT_LAST);
  end

  always_comb begin
    unique case (rdAddr)
      ADDR_VALUE: rdData = setpoint;
      ADDR_CTRL:  rdData = {{(DATA_W-1){1'b0}}, runFlag};
      default:    rdData = '0;
    endcase
  end

  // R5: a setpoint write is visible one edge later
  p_value_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_VALUE) |=> (setpoint == $past(wrData)));
  // R5: a control write sets the run flag
  p_run_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_CTRL) |=> (strb.run == $past(wrData[0])));
  // R8: writes to unused addresses leave both registers alone
  p_unused_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != ADDR_VALUE && wrAddr != ADDR_CTRL) |=> ($stable(setpoint) && $stable(strb.run)));
  // R3: ticks are never back to back
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |=> !strb.tick);
endmodule

// File: rtl/sdd_datapath.sv
module sdd_datapath
  import sdd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  sddStrobes_t       strb,
  input  logic [DATA_W-1:0] setpoint,
  output logic              dacOut,
  output logic              dacDrive
);
  localparam logic [DATA_W-1:0] QUARTER = DATA_W'(1) << (DATA_W - 2);

  logic [DATA_W-1:0] offsetCode;
  logic [DATA_W-1:0] stepCode;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] acc;
  logic              bitReg;

  always_comb begin
    offsetCode = {~setpoint[DATA_W-1], setpoint[DATA_W-2:0]};
    stepCode   = (offsetCode >> 1) + QUARTER;
    sum        = {1'b0, acc} + {1'b0, stepCode};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      bitReg <= 1'b0;
    end else if (!strb.run) begin
      acc    <= '0;
      bitReg <= 1'b0;
    end else if (strb.tick) begin
      acc    <= sum[DATA_W-1:0];
      bitReg <= sum[DATA_W];
    end
  end

  assign dacOut   = bitReg & strb.run;
  assign dacDrive = strb.run;

  // R4: stopping empties the accumulator
  p_acc_cleared_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (acc == '0));
  // R3: output holds between ticks while running
  p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.tick && $past(strb.run)) |=> (strb.run -> $stable(dacOut)));
  // R6: accumulator only moves on a tick while running
  p_acc_moves_on_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !strb.tick) |=> $stable(acc));
endmodule

// File: rtl/sigma_delta_dac.sv
module sigma_delta_dac
  import sdd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              dacOut,
  output logic              dacDrive
);
  sddStrobes_t       strb;
  logic [DATA_W-1:0] setpoint;

  sdd_ctrl #(.DATA_W(DATA_W), .TICK_DIV(TICK_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .setpoint(setpoint), .strb(strb)
  );

  sdd_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .setpoint(setpoint),
    .dacOut(dacOut), .dacDrive(dacDrive)
  );

  // R7: the pin is driven only while running
  p_drive_off_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dacDrive |-> !dacOut);
endmodule

// File: tb/sigma_delta_dac_test.sv
module sigma_delta_dac_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int K   = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        dacOut;
  logic        dacDrive;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int enCyc = 0;

  sigma_delta_dac #(.DATA_W(16), .TICK_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .dacOut(dacOut), .dacDrive(dacDrive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 2'd1 && d[0]) enCyc = cyc;
  endtask

  function automatic longint codeOf(input int v);
    return ((v + 32768) >> 1) + 16384;
  endfunction

  task automatic waitTick(input int k);
    while (cyc < enCyc + k * DIV) begin
      @(posedge clk); #1;
    end
    @(negedge clk);
  endtask

  task automatic startRun(input int v);
    regWrite(2'd1, 16'd0);
    regWrite(2'd0, 16'(v));
    regWrite(2'd1, 16'd1);
  endtask

  task automatic testReset();
    rdAddr = 2'd0; #1;
    check("R1 setpoint", rdData, 0);
    rdAddr = 2'd1; #1;
    check("R1 run flag", rdData, 0);
    check("R1 dacOut", dacOut, 0);
    check("R1 dacDrive", dacDrive, 0);
  endtask

  task automatic testDuty(input int v);
    int ones = 0;
    startRun(v);
    for (int k = 1; k <= K; k++) begin
      waitTick(k);
      if (dacOut) ones++;
    end
    check($sformatf("R2 ones for value %0d", v), ones, (K * codeOf(v)) >> 16);
  endtask

  task automatic testTiming();
    startRun(-32768);
    check("R7 drive while running", dacDrive, 1);
    waitTick(1);
    check("R3 bit 1", dacOut, 0);
    waitTick(3);
    check("R3 bit 3", dacOut, 0);
    @(posedge clk); #1;
    while (cyc < enCyc + 4 * DIV - 1) begin @(posedge clk); #1; end
    check("R3 held before tick 4", dacOut, 0);
    waitTick(4);
    check("R3 bit 4 at tick", dacOut, 1);
    @(negedge clk);
    check("R3 bit 4 held", dacOut, 1);
  endtask

  task automatic testLiveChange();
    startRun(0);
    waitTick(1);
    check("R6 first bit value 0", dacOut, 0);
    regWrite(2'd0, 16'h8000);
    waitTick(2);
    check("R6 bit after change", dacOut, 0);
    waitTick(3);
    check("R6 carry keeps accumulator", dacOut, 1);
  endtask

  task automatic testOff();
    startRun(0);
    waitTick(1);
    regWrite(2'd1, 16'd0);
    check("R4 out low when off", dacOut, 0);
    check("R7 drive low when off", dacDrive, 0);
    regWrite(2'd0, 16'h8000);
    regWrite(2'd1, 16'd1);
    waitTick(1); check("R4 restart bit 1", dacOut, 0);
    waitTick(2); check("R4 restart bit 2", dacOut, 0);
    waitTick(3); check("R4 restart bit 3", dacOut, 0);
    waitTick(4); check("R4 restart bit 4", dacOut, 1);
  endtask

  task automatic testRegs();
    regWrite(2'd0, 16'h1234);
    rdAddr = 2'd0; #1;
    check("R5 readback value", rdData, 16'h1234);
    rdAddr = 2'd1; #1;
    check("R5 readback run", rdData, 1);
    regWrite(2'd2, 16'h0000);
    regWrite(2'd3, 16'hFFFE);
    rdAddr = 2'd0; #1;
    check("R8 value untouched", rdData, 16'h1234);
    rdAddr = 2'd1; #1;
    check("R8 run untouched", rdData, 1);
    rdAddr = 2'd2; #1;
    check("R8 read addr2", rdData, 0);
    rdAddr = 2'd3; #1;
    check("R8 read addr3", rdData, 0);
    check("R8 drive still on", dacDrive, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testDuty(0);
    testDuty(-32768);
    testDuty(32767);
    testDuty(1000);
    testTiming();
    testLiveChange();
    testOff();
    testRegs();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule